// File: doc/BRIEF.md
# Connection Memory Bulk Fill Engine

This block loads one fixed word into every location of a time-slot switch connection memory. Software arms the feature with a ready bit, then launches a fill with a single register write that carries a start bit and a 3-bit fill pattern. The engine waits for the next frame-start pulse and then walks the whole address range, one location per clock. Each word gets the pattern in its top three bits and zeros in the lower thirteen. The run is timed against the frame grid and finishes when two frame pulses have passed since the walk began. At that point the start bit clears itself, so software can poll for completion.

A run can be stopped part way by a register write that clears either the start bit or the ready bit. Locations that were already filled keep the new word, and no further memory writes are made. The connection memory, the switching datapath and any arbitration with per-channel memory access sit outside the block. The engine only drives the memory's write port.

Top module: `cm_block_fill`

## Requirements
- R1: After synchronous reset, `busy` is 0, `cm_we` is 0 and `reg_rdata` reads 0.
- R2: A write to the control address with the start bit (bit 1) and the ready bit (bit 0) both 1, made while idle, launches a run. `busy` is 1 from the next cycle. The pattern in bits 10:8 of that same write is captured for the run.
- R3: While idle, a control write with the ready bit 0 does not launch a run, whatever the start bit holds. `busy` stays 0, no memory write occurs and the start bit reads back 0.
- R4: A write to any register address other than the control address changes neither the readback value nor `busy`, and it causes no memory write.
- R5: After a launch, no memory write occurs until a frame pulse is sampled. The first write, to address 0, is presented in the cycle after the edge that samples that pulse.
- R6: During the walk, `cm_we` is high for one location per clock, with the address rising by one from 0 to the last address. Every address is written exactly once, with the word {pattern, 13 zero bits}.
- R7: The run completes at the edge that samples the second frame pulse after the walk-starting pulse, or after the last write if that comes later. At completion `busy` falls and the start bit reads 0, while the ready bit keeps its value.
- R8: While busy, a control write with the start bit 0 or the ready bit 0 aborts the run. From the next cycle `cm_we` and `busy` are 0. Words already written keep their value and the remaining locations are never written.
- R9: While busy, a control write with both the start bit and the ready bit at 1 is ignored. The run goes on with the captured pattern, and the pattern field reads back unchanged.
- R10: The control register reads back the pattern in bits 10:8, the start (running) bit in bit 1 and the ready bit in bit 0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Control register readback |
| frame_pulse | input | 1 | One-cycle frame-start pulse |
| cm_we | output | 1 | Connection memory write enable |
| cm_addr | output | ADDR_W | Connection memory write address |
| cm_wdata | output | 16 | Connection memory write data |
| busy | output | 1 | High from the launching write until completion or abort |

## Verification
A sequencer stuck in the wrong state appears on `cm_we` within one clock. Examples are writes that begin before a frame pulse, a skipped or repeated address, or a write that continues after an abort. A frame counter that is off by one moves the fall of `busy` by a whole frame, and the edge-by-edge check of `busy` against sampled frame pulses catches it at that frame boundary. A corrupted pattern capture shows in the first word written, and the bench's shadow copy of the memory shows any location that was missed or written outside the run.

// File: rtl/cmf_pkg.sv
package cmf_pkg;

    // Register and memory word width
    localparam int CW      = 16;
    // Fill pattern width and its field position in the control word
    localparam int PAT_W   = 3;
    localparam int PAT_LSB = 8;
    // Control bits
    localparam int ARM_BIT = 0;
    localparam int GO_BIT  = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SWEEP,
        ST_LINGER
    } fill_state_e;

    typedef struct packed {
        logic [PAT_W-1:0] pattern;
        logic             go;
        logic             arm;
    } ctrl_fields_t;

    typedef struct packed {
        logic             launch;
        logic             abort;
        logic [PAT_W-1:0] pattern;
    } fill_cmd_t;

    function automatic ctrl_fields_t unpack_ctrl(input logic [CW-1:0] w);
        ctrl_fields_t f;
        f.pattern = w[PAT_LSB +: PAT_W];
        f.go      = w[GO_BIT];
        f.arm     = w[ARM_BIT];
        return f;
    endfunction

    function automatic logic [CW-1:0] pack_ctrl(input ctrl_fields_t f);
        logic [CW-1:0] w;
        w                   = '0;
        w[PAT_LSB +: PAT_W] = f.pattern;
        w[GO_BIT]           = f.go;
        w[ARM_BIT]          = f.arm;
        return w;
    endfunction

    function automatic logic [CW-1:0] fill_word(input logic [PAT_W-1:0] p);
        return {p, {(CW-PAT_W){1'b0}}};
    endfunction

endpackage

// File: rtl/cmf_ctrl_reg.sv
module cmf_ctrl_reg
    import cmf_pkg::*;
#(
    parameter int REG_AW    = 4,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [CW-1:0]     reg_wdata,
    input  logic              busy,
    output fill_cmd_t         cmd,
    output logic [CW-1:0]     reg_rdata
);

    logic             sel;
    ctrl_fields_t     wf;
    ctrl_fields_t     rd_f;
    logic             arm_q;
    logic [PAT_W-1:0] pat_q;
    logic             launch;
    logic             abort;

    assign sel = reg_wr && (reg_addr == REG_AW'(CTRL_ADDR));
    assign wf  = unpack_ctrl(reg_wdata);

    // Launch needs ready and start in one write while idle; the start bit
    // reads as 0 when idle, so this write is its 0-to-1 transition.
    assign launch = sel && !busy && wf.arm && wf.go;
    // Clearing either control bit while running stops the run.
    assign abort  = sel && busy && (!wf.go || !wf.arm);

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b0;
            pat_q <= '0;
        end else if (sel && (!busy || abort)) begin
            arm_q <= wf.arm;
            pat_q <= wf.pattern;
        end
    end

    assign cmd.launch  = launch;
    assign cmd.abort   = abort;
    assign cmd.pattern = pat_q;

    always_comb begin
        rd_f.pattern = pat_q;
        rd_f.go      = busy;
        rd_f.arm     = arm_q;
        reg_rdata    = pack_ctrl(rd_f);
    end

    // Unarmed writes never start a run
    assert_unarmed_no_start_R3: assert property (@(posedge clk) disable iff (rst)
        (sel && !wf.arm && !busy) |=> !busy);

    // Foreign addresses leave the register and the engine alone
    assert_foreign_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr != REG_AW'(CTRL_ADDR) && !busy) |=> ($stable(reg_rdata) && !busy));

    // Busy-time writes with both bits set keep the captured pattern
    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (sel && busy && wf.go && wf.arm) |=> $stable(cmd.pattern));

endmodule

// File: rtl/cmf_frame_tally.sv
module cmf_frame_tally #(
    parameter int RUN_FRAMES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic count_en,
    input  logic frame_pulse,
    output logic frames_due
);

    localparam int CNT_W = $clog2(RUN_FRAMES + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   sum;

    assign sum        = {1'b0, cnt} + (CNT_W+1)'(frame_pulse);
    // True when the pulse at this edge (if any) completes the frame budget
    assign frames_due = count_en && (sum >= (CNT_W+1)'(RUN_FRAMES));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (count_en && frame_pulse && cnt != CNT_W'(RUN_FRAMES)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_tally_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(RUN_FRAMES));

endmodule

// File: rtl/cmf_sweeper.sv
module cmf_sweeper
    import cmf_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  fill_cmd_t         cmd,
    input  logic              frame_pulse,
    input  logic              frames_due,
    output logic              tally_clear,
    output logic              tally_en,
    output logic              cm_we,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [CW-1:0]     cm_wdata,
    output logic              busy
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    fill_state_e       state;
    logic [ADDR_W-1:0] addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            addr  <= '0;
        end else if (cmd.abort) begin
            state <= ST_IDLE;
            addr  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd.launch) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    addr <= '0;
                    if (frame_pulse) state <= ST_SWEEP;
                end
                ST_SWEEP: begin
                    addr <= addr + 1'b1;
                    if (addr == LAST_ADDR) state <= frames_due ? ST_IDLE : ST_LINGER;
                end
                ST_LINGER: begin
                    if (frames_due) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tally_clear = (state == ST_WAIT) || (state == ST_IDLE);
    assign tally_en    = (state == ST_SWEEP) || (state == ST_LINGER);
    assign cm_we       = (state == ST_SWEEP);
    assign cm_addr     = addr;
    assign cm_wdata    = fill_word(cmd.pattern);
    assign busy        = (state != ST_IDLE);

    assert_launch_busy_R2: assert property (@(posedge clk) disable iff (rst)
        cmd.launch |=> busy);

    assert_first_write_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cm_we) |-> (cm_addr == '0 && $past(frame_pulse)));

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (cm_we && $past(cm_we)) |-> (cm_addr == ADDR_W'($past(cm_addr) + 1'b1)));

    assert_abort_halts_R8: assert property (@(posedge clk) disable iff (rst)
        cmd.abort |=> (!cm_we && !busy));

    assert_finish_timing_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(cmd.abort)) |->
            ($past(frame_pulse) || $past(cm_we && cm_addr == LAST_ADDR)));

endmodule

// File: rtl/cm_block_fill.sv
module cm_block_fill
    import cmf_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int REG_AW     = 4,
    parameter int CTRL_ADDR  = 0,
    parameter int RUN_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              frame_pulse,
    output logic              cm_we,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [15:0]       cm_wdata,
    output logic              busy
);

    fill_cmd_t cmd;
    logic      tally_clear;
    logic      tally_en;
    logic      frames_due;

    cmf_ctrl_reg #(
        .REG_AW    (REG_AW),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .cmd       (cmd),
        .reg_rdata (reg_rdata)
    );

    cmf_frame_tally #(
        .RUN_FRAMES (RUN_FRAMES)
    ) u_tally (
        .clk         (clk),
        .rst         (rst),
        .clear       (tally_clear),
        .count_en    (tally_en),
        .frame_pulse (frame_pulse),
        .frames_due  (frames_due)
    );

    cmf_sweeper #(
        .ADDR_W (ADDR_W)
    ) u_sweep (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .frame_pulse (frame_pulse),
        .frames_due  (frames_due),
        .tally_clear (tally_clear),
        .tally_en    (tally_en),
        .cm_we       (cm_we),
        .cm_addr     (cm_addr),
        .cm_wdata    (cm_wdata),
        .busy        (busy)
    );

    // Low word bits are always zero whenever the memory is written
    assert_low_bits_zero_R6: assert property (@(posedge clk) disable iff (rst)
        cm_we |-> (cm_wdata[12:0] == '0));

endmodule

// File: tb/cm_block_fill_bench.sv
module cm_block_fill_bench;

    localparam int ADDR_W = 11;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int P      = 1500;
    localparam int WDOG   = 190000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [3:0]        reg_addr = '0;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;
    logic              frame_pulse = 1'b0;
    logic              cm_we;
    logic [ADDR_W-1:0] cm_addr;
    logic [15:0]       cm_wdata;
    logic              busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit exp_run = 0, started = 0, aborting = 0;
    int pulses = 0, writes = 0;
    int nxt = 0;
    logic [2:0]  exp_pat = '0;
    logic [15:0] shadow [DEPTH];

    always #2 clk = ~clk;

    cm_block_fill u_cm_block_fill (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_pulse(frame_pulse),
        .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata), .busy(busy)
    );

    function automatic logic [15:0] ctrl_word(input logic [2:0] p, input bit go, input bit arm);
        return {5'b0, p, 6'b0, go, arm};
    endfunction

    function automatic logic [15:0] fill_of(input logic [2:0] p);
        return {p, 13'b0};
    endfunction

    function automatic logic [15:0] init_of(input int a);
        return 16'h1555 ^ 16'(a);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %0h exp %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Monitor, frame generator and watchdog, all at the falling edge
    always @(negedge clk) begin
        logic seen;
        seen = frame_pulse;
        if (!rst) begin
            if (cm_we) begin
                if (!exp_run) begin
                    chk(0, "R3 R4 R8 write while idle", cm_addr, 0);
                end else begin
                    chk(cm_addr == ADDR_W'(nxt), "R6 address", cm_addr, nxt);
                    chk(cm_wdata == fill_of(exp_pat), "R6 data", cm_wdata, fill_of(exp_pat));
                    shadow[cm_addr] = cm_wdata;
                    nxt++;
                    writes++;
                end
            end
            if (exp_run && !aborting) begin
                if (!started) begin
                    chk(busy == 1'b1, "R2 busy held", busy, 1);
                    if (seen) begin
                        chk(cm_we == 1'b1, "R5 start on pulse", cm_we, 1);
                        started = 1;
                    end else begin
                        chk(cm_we == 1'b0, "R5 no early write", cm_we, 0);
                    end
                end else begin
                    if (seen) pulses++;
                    if (pulses >= 2 && writes == DEPTH) begin
                        chk(busy == 1'b0, "R7 completion", busy, 0);
                        exp_run = 0;
                    end else begin
                        chk(busy == 1'b1, "R7 still running", busy, 1);
                    end
                end
            end
        end
        cyc = cyc + 1;
        frame_pulse <= (cyc % P == 0);
        if (cyc >= WDOG) begin
            errors++;
            $display("FAIL watchdog R7 act %0d exp <%0d", cyc, WDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic launch(input logic [2:0] p);
        for (int i = 0; i < DEPTH; i++) shadow[i] = init_of(i);
        @(posedge clk);
        while (((cyc + 1) % P) == 0) @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = ctrl_word(p, 1, 1);
        @(negedge clk);
        reg_wr = 1'b0;
        exp_pat = p; pulses = 0; writes = 0; nxt = 0;
        started = 0; aborting = 0; exp_run = 1;
        chk(busy == 1'b1, "R2 launch", busy, 1);
        chk(reg_rdata == ctrl_word(p, 1, 1), "R10 running readback", reg_rdata, ctrl_word(p, 1, 1));
    endtask

    task automatic full_run(input logic [2:0] p, input logic [2:0] other, input int mid);
        int bad;
        launch(p);
        wait (writes >= mid);
        reg_write(4'h0, ctrl_word(other, 1, 1));
        chk(reg_rdata[10:8] == p, "R9 pattern held", reg_rdata[10:8], p);
        chk(busy == 1'b1, "R9 run continues", busy, 1);
        wait (!exp_run);
        @(negedge clk);
        chk(busy == 1'b0, "R7 busy low", busy, 0);
        chk(reg_rdata == ctrl_word(p, 0, 1), "R7 start self-clear", reg_rdata, ctrl_word(p, 0, 1));
        bad = 0;
        for (int i = 0; i < DEPTH; i++) if (shadow[i] != fill_of(p)) bad++;
        chk(bad == 0, "R6 all words filled", bad, 0);
        chk(writes == DEPTH, "R6 write count", writes, DEPTH);
    endtask

    task automatic abort_run(input logic [2:0] p, input bit by_arm, input int after);
        int bad;
        launch(p);
        wait (writes >= after);
        @(negedge clk);
        aborting = 1;
        reg_wr = 1'b1; reg_addr = 4'h0;
        reg_wdata = by_arm ? ctrl_word(p, 1, 0) : ctrl_word(p, 0, 1);
        @(negedge clk);
        reg_wr = 1'b0;
        chk(busy == 1'b0, "R8 busy drops", busy, 0);
        chk(cm_we == 1'b0, "R8 writes stop", cm_we, 0);
        exp_run = 0;
        chk(reg_rdata == ctrl_word(p, 0, !by_arm), "R8 readback", reg_rdata, ctrl_word(p, 0, !by_arm));
        repeat (2 * P) @(negedge clk);
        chk(writes > 0 && writes < DEPTH, "R8 partial", writes, after);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < writes && shadow[i] != fill_of(p)) bad++;
            if (i >= writes && shadow[i] != init_of(i)) bad++;
        end
        chk(bad == 0, "R8 prefix kept, rest untouched", bad, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < DEPTH; i++) shadow[i] = init_of(i);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(cm_we == 1'b0, "R1 we", cm_we, 0);
        chk(reg_rdata == 16'h0, "R1 rdata", reg_rdata, 0);

        // Readback layout
        reg_write(4'h0, ctrl_word(3'd5, 0, 1));
        chk(reg_rdata == 16'h0501, "R10 layout", reg_rdata, 16'h0501);
        reg_write(4'h0, 16'hF8FC);
        chk(reg_rdata == 16'h0000, "R10 other bits zero", reg_rdata, 0);

        // Start without ready
        reg_write(4'h0, ctrl_word(3'd2, 1, 0));
        repeat (2 * P) @(negedge clk);
        chk(busy == 1'b0, "R3 no launch", busy, 0);
        chk(reg_rdata == ctrl_word(3'd2, 0, 0), "R3 start reads 0", reg_rdata, ctrl_word(3'd2, 0, 0));

        // Other address
        reg_write(4'h3, ctrl_word(3'd6, 1, 1));
        repeat (2 * P) @(negedge clk);
        chk(busy == 1'b0, "R4 no launch", busy, 0);
        chk(reg_rdata == ctrl_word(3'd2, 0, 0), "R4 rdata unchanged", reg_rdata, ctrl_word(3'd2, 0, 0));

        // Directed: pattern 7, then pattern 0
        full_run(3'd7, 3'd1, 10);
        full_run(3'd0, 3'd5, 1900);

        // Random runs at random frame phase
        for (int k = 0; k < 4; k++) begin
            repeat ($urandom_range(0, P)) @(negedge clk);
            full_run(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), $urandom_range(1, 2000));
        end

        // Aborts: first and last-but-few words, then random
        abort_run(3'd3, 1'b0, 1);
        abort_run(3'd6, 1'b1, DEPTH - 3);
        for (int k = 0; k < 3; k++) begin
            repeat ($urandom_range(0, P)) @(negedge clk);
            abort_run(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), $urandom_range(1, 2000));
        end

        // Engine usable again after an abort
        full_run(3'd4, 3'd2, 500);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule